// File: doc/BRIEF.md
# PHY Management Register File

This block holds the management-side registers of a 10/100 Ethernet transceiver. Eleven 16-bit registers are reached through a single-cycle access port with a 5-bit register address. The serial management framing sits outside the block and turns frames into `acc_en`/`acc_wr` strobes. The line-side status sources (link, jabber, remote fault, negotiation done, page received, receive error) arrive as input flags. Partner ability arrives as a 16-bit word.

Each register bit has its own access type: read/write, read-only constant, live status, or sticky status that clears when its register is read. Sticky bits come in two kinds. Latch-low bits record a drop. Latch-high bits record an event. Power-up defaults come from strap pins. A write to the control register can reset the whole register set. An interrupt status register and an enable mask drive a single interrupt line. One interrupt source is a receive-error counter reaching its threshold.

Top module: `phy_mgmt_regs`

## Requirements
- R1: Implemented addresses are 0 (control), 1 (status), 2 and 3 (identifier), 4 (advertisement), 5 (partner ability), 6 (expansion), 16 (config), 17 (interrupt status), 18 (interrupt enable) and 19 (receive-error count). A read of any other address returns 0.
- R2: A read access loads `acc_rdata` on the next clock edge. `acc_rdata` holds its value through cycles with no read.
- R3: Writes change only read/write bits. The read/write masks are: control 0x7D00, advertisement 0x25E0, config 0x000F, interrupt enable 0x003F. Writes to every other bit and register are ignored. In the status register, bits 14..11, 3 and 0 always read 1 and bit 15 always reads 0. Advertisement bits 4..0 always read 00001.
- R4: Writing 1 to control bit 15 returns every register, sticky bit and the counter to its default at that edge. Control bit 15 always reads 0.
- R5: Reset defaults of the control register are: bit 13 = 1, bit 8 = 1, bit 12 = `strap_an_en`, and all other bits 0. Config bit 0 (transmit isolate) resets to 1 exactly when `strap_phy_addr` is 00000.
- R6: Advertisement bits 8..5 reset from `strap_adv_sel` when `strap_an_en`=1, using the map 0→1111, 1→1100, 2→0001, 3→0011. When `strap_an_en`=0 they reset to 1111.
- R7: Status bit 2 latches low. It drops in the cycle after `link_ok` is 0 and stays 0 until status is read. A read reloads it with the `link_ok` value of the read cycle. It is 0 after reset.
- R8: Status bit 1 (`jabber`) and bit 4 (`remote_fault`) latch high and clear on a status read. Expansion bit 1 (`page_rx`) latches high and clears on an expansion read. Expansion bit 0 reads `|lp_ability`. Status bit 5 reads `an_done` live. Partner ability reads `lp_ability`.
- R9: The interrupt status bits latch high and clear when that register is read. An event present in the read cycle survives the clear. The bit sources are: bit 0 receive-error threshold, bit 1 `page_rx`, bit 2 `!link_ok`, bit 3 `jabber`, bit 4 `remote_fault`, bit 5 `an_done`.
- R10: Register 19 counts `rx_err` cycles, saturates at 0xFFFF and clears on read; an error in the read cycle counts as 1. Interrupt bit 0 sets on the cycle the count becomes 64.
- R11: `irq` is high exactly when some interrupt status bit and its enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_an_en | input | 1 | Auto-negotiation enable strap |
| strap_phy_addr | input | 5 | PHY address strap |
| strap_adv_sel | input | 2 | Advertisement default select strap |
| acc_en | input | 1 | Access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Register address |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid the cycle after a read |
| link_ok | input | 1 | Link good flag |
| jabber | input | 1 | Jabber flag |
| remote_fault | input | 1 | Remote fault flag |
| an_done | input | 1 | Negotiation complete flag |
| page_rx | input | 1 | Page received pulse |
| rx_err | input | 1 | Receive error pulse |
| lp_ability | input | 16 | Partner ability word |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the read cycle that coincides with an event. A design that cleared a sticky bit after capturing the read data would lose the page event. It also checks the latch-low link bit on the read that follows a drop; a design that simply tracked `link_ok` would report the link as up. The counter is driven to 63 and then 64 errors, so an off-by-one threshold raises the interrupt one error early or late. A software reset issued after the enable mask and advertisement were rewritten would leave stale values if any register missed the reset.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int DW   = 16;
    localparam int AW   = 5;
    localparam int NRW  = 4;
    localparam int NINT = 6;

    typedef enum logic [AW-1:0] {
        A_CTRL = 5'd0,
        A_STAT = 5'd1,
        A_ID1  = 5'd2,
        A_ID2  = 5'd3,
        A_ADV  = 5'd4,
        A_LPA  = 5'd5,
        A_EXP  = 5'd6,
        A_CFG  = 5'd16,
        A_ISR  = 5'd17,
        A_IER  = 5'd18,
        A_ERRC = 5'd19
    } reg_addr_e;

    typedef struct packed {
        logic          en;
        logic          wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } acc_t;

    // read/write register slots: index 0 control, 1 advertisement, 2 config, 3 enable
    localparam logic [NRW-1:0][AW-1:0] RW_ADDR = {A_IER, A_CFG, A_ADV, A_CTRL};
    localparam logic [NRW-1:0][DW-1:0] RW_MASK = {16'h003F, 16'h000F, 16'h25E0, 16'h7D00};

    // interrupt bit positions
    localparam int IB_ERR  = 0;
    localparam int IB_PAGE = 1;
    localparam int IB_LINK = 2;
    localparam int IB_JAB  = 3;
    localparam int IB_RF   = 4;
    localparam int IB_AND  = 5;

    function automatic logic [3:0] adv_default(input logic an_en, input logic [1:0] sel);
        if (!an_en) return 4'b1111;
        case (sel)
            2'd0:    return 4'b1111;
            2'd1:    return 4'b1100;
            2'd2:    return 4'b0001;
            default: return 4'b0011;
        endcase
    endfunction

endpackage

// File: rtl/phy_mgmt_sticky.sv
module phy_mgmt_sticky #(
    parameter bit LATCH_LOW = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic ev,
    output logic q
);
    generate
        if (LATCH_LOW) begin : g_low
            always_ff @(posedge clk) begin
                if (rst)      q <= 1'b0;
                else if (clr) q <= ev;
                else          q <= q & ev;
            end
            assert_drop_held_R7: assert property (@(posedge clk) disable iff (rst)
                !ev |=> !q);
        end else begin : g_high
            always_ff @(posedge clk) begin
                if (rst) q <= 1'b0;
                else     q <= (q & ~clr) | ev;
            end
            assert_event_held_R8: assert property (@(posedge clk) disable iff (rst)
                ev |=> q);
        end
    endgenerate
endmodule

// File: rtl/phy_mgmt_rwreg.sv
module phy_mgmt_rwreg
    import phy_mgmt_pkg::*;
#(
    parameter logic [DW-1:0] MASK = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [DW-1:0] def_i,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= def_i;
        else if (we) q <= (q & ~MASK) | (wdata & MASK);
    end

    assert_ro_kept_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & ~MASK) == ($past(q) & ~MASK)));
endmodule

// File: rtl/phy_mgmt_errcnt.sv
module phy_mgmt_errcnt #(
    parameter int CNT_W  = 16,
    parameter int THRESH = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             err,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    localparam logic [CNT_W-1:0] MAXV = '1;
    localparam logic [CNT_W-1:0] THR  = CNT_W'(THRESH);

    logic [CNT_W-1:0] nxt;

    always_comb begin
        if (clr)                     nxt = {{(CNT_W-1){1'b0}}, err};
        else if (err && cnt != MAXV) nxt = cnt + 1'b1;
        else                         nxt = cnt;
        hit = err && (nxt == THR);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= nxt;
    end

    assert_sat_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (cnt == MAXV && !clr) |=> cnt == MAXV);
    assert_no_drop_R10: assert property (@(posedge clk) disable iff (rst)
        !clr |=> cnt >= $past(cnt));
endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
    import phy_mgmt_pkg::*;
#(
    parameter logic [DW-1:0] ID_HI  = 16'h0203,
    parameter logic [DW-1:0] ID_LO  = 16'h5C41,
    parameter int            CNT_W  = 16,
    parameter int            THRESH = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strap_an_en,
    input  logic [AW-1:0] strap_phy_addr,
    input  logic [1:0]    strap_adv_sel,
    input  logic          acc_en,
    input  logic          acc_wr,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    output logic [DW-1:0] acc_rdata,
    input  logic          link_ok,
    input  logic          jabber,
    input  logic          remote_fault,
    input  logic          an_done,
    input  logic          page_rx,
    input  logic          rx_err,
    input  logic [DW-1:0] lp_ability,
    output logic          irq
);
    acc_t acc;
    assign acc = '{en: acc_en, wr: acc_wr, addr: acc_addr, wdata: acc_wdata};

    logic rd, wr, soft_rst, rst_all;
    assign rd       = acc.en && !acc.wr;
    assign wr       = acc.en && acc.wr;
    assign soft_rst = wr && (acc.addr == A_CTRL) && acc.wdata[15];
    assign rst_all  = rst || soft_rst;

    // read/write registers
    logic [NRW-1:0][DW-1:0] rw_def, rw_q;
    always_comb begin
        rw_def[0] = 16'h2100 | (DW'(strap_an_en) << 12);
        rw_def[1] = 16'h0001 | (DW'(adv_default(strap_an_en, strap_adv_sel)) << 5);
        rw_def[2] = {15'b0, strap_phy_addr == '0};
        rw_def[3] = '0;
    end

    genvar g;
    generate
        for (g = 0; g < NRW; g++) begin : g_rw
            phy_mgmt_rwreg #(.MASK(RW_MASK[g])) u_rw (
                .clk   (clk),
                .rst   (rst_all),
                .we    (wr && !soft_rst && acc.addr == RW_ADDR[g]),
                .def_i (rw_def[g]),
                .wdata (acc.wdata),
                .q     (rw_q[g])
            );
        end
    endgenerate

    // sticky status bits
    logic clr_stat, clr_exp, clr_isr, clr_cnt;
    assign clr_stat = rd && acc.addr == A_STAT;
    assign clr_exp  = rd && acc.addr == A_EXP;
    assign clr_isr  = rd && acc.addr == A_ISR;
    assign clr_cnt  = rd && acc.addr == A_ERRC;

    logic link_lat, jab_lat, rf_lat, page_lat;

    phy_mgmt_sticky #(.LATCH_LOW(1'b1)) u_link (
        .clk(clk), .rst(rst_all), .clr(clr_stat), .ev(link_ok), .q(link_lat));
    phy_mgmt_sticky #(.LATCH_LOW(1'b0)) u_jab (
        .clk(clk), .rst(rst_all), .clr(clr_stat), .ev(jabber), .q(jab_lat));
    phy_mgmt_sticky #(.LATCH_LOW(1'b0)) u_rf (
        .clk(clk), .rst(rst_all), .clr(clr_stat), .ev(remote_fault), .q(rf_lat));
    phy_mgmt_sticky #(.LATCH_LOW(1'b0)) u_page (
        .clk(clk), .rst(rst_all), .clr(clr_exp), .ev(page_rx), .q(page_lat));

    // receive error counter
    logic [CNT_W-1:0] err_cnt;
    logic             err_hit;

    phy_mgmt_errcnt #(.CNT_W(CNT_W), .THRESH(THRESH)) u_cnt (
        .clk(clk), .rst(rst_all), .clr(clr_cnt), .err(rx_err),
        .cnt(err_cnt), .hit(err_hit));

    // interrupt status
    logic [NINT-1:0] int_ev, int_q;
    always_comb begin
        int_ev          = '0;
        int_ev[IB_ERR]  = err_hit;
        int_ev[IB_PAGE] = page_rx;
        int_ev[IB_LINK] = !link_ok;
        int_ev[IB_JAB]  = jabber;
        int_ev[IB_RF]   = remote_fault;
        int_ev[IB_AND]  = an_done;
    end

    generate
        for (g = 0; g < NINT; g++) begin : g_int
            phy_mgmt_sticky #(.LATCH_LOW(1'b0)) u_int (
                .clk(clk), .rst(rst_all), .clr(clr_isr), .ev(int_ev[g]), .q(int_q[g]));
        end
    endgenerate

    assign irq = |(int_q & rw_q[3][NINT-1:0]);

    // read mux
    logic [DW-1:0] rd_val;
    always_comb begin
        unique case (acc.addr)
            A_CTRL:  rd_val = rw_q[0];
            A_STAT:  rd_val = {1'b0, 4'b1111, 5'b0, an_done, rf_lat, 1'b1,
                               link_lat, jab_lat, 1'b1};
            A_ID1:   rd_val = ID_HI;
            A_ID2:   rd_val = ID_LO;
            A_ADV:   rd_val = rw_q[1];
            A_LPA:   rd_val = lp_ability;
            A_EXP:   rd_val = {14'b0, page_lat, |lp_ability};
            A_CFG:   rd_val = rw_q[2];
            A_ISR:   rd_val = {{(DW-NINT){1'b0}}, int_q};
            A_IER:   rd_val = rw_q[3];
            A_ERRC:  rd_val = DW'(err_cnt);
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     acc_rdata <= '0;
        else if (rd) acc_rdata <= rd_val;
    end

    assert_soft_reset_R4: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (rw_q[0] == (16'h2100 | (DW'($past(strap_an_en)) << 12))) && (rw_q[3] == '0));
    assert_isr_cleared_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_isr && int_ev == '0) |=> int_q == '0);
    assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(acc_rdata));
endmodule

// File: tb/phy_mgmt_regs_tb_top.sv
`timescale 1ns/1ps
module phy_mgmt_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strap_an_en = 1'b1;
    logic [4:0]  strap_phy_addr = 5'd0;
    logic [1:0]  strap_adv_sel = 2'd1;
    logic        acc_en = 1'b0, acc_wr = 1'b0;
    logic [4:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        link_ok = 1'b1, jabber = 1'b0, remote_fault = 1'b0;
    logic        an_done = 1'b0, page_rx = 1'b0, rx_err = 1'b0;
    logic [15:0] lp_ability = 16'h41E1;
    logic        irq;

    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    phy_mgmt_regs dut_i (
        .clk(clk), .rst(rst), .strap_an_en(strap_an_en), .strap_phy_addr(strap_phy_addr),
        .strap_adv_sel(strap_adv_sel), .acc_en(acc_en), .acc_wr(acc_wr), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .link_ok(link_ok), .jabber(jabber),
        .remote_fault(remote_fault), .an_done(an_done), .page_rx(page_rx), .rx_err(rx_err),
        .lp_ability(lp_ability), .irq(irq));

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_ctrl, m_adv, m_cfg, m_ier, m_rdata;
    bit          m_link, m_jab, m_rf, m_page;
    logic [5:0]  m_isr;
    int          m_cnt;
    logic [4:0]  m_last;

    function automatic logic [3:0] adv_map(bit an, logic [1:0] s);
        if (!an) return 4'hF;
        if (s == 2'd0) return 4'hF;
        if (s == 2'd1) return 4'hC;
        if (s == 2'd2) return 4'h1;
        return 4'h3;
    endfunction

    task automatic model_defaults();
        m_ctrl = strap_an_en ? 16'h3100 : 16'h2100;
        m_adv  = 16'h0001 | (16'(adv_map(strap_an_en, strap_adv_sel)) << 5);
        m_cfg  = (strap_phy_addr == 5'd0) ? 16'h0001 : 16'h0000;
        m_ier  = 16'h0000;
        m_link = 0; m_jab = 0; m_rf = 0; m_page = 0; m_isr = '0; m_cnt = 0;
    endtask

    function automatic logic [15:0] model_read(logic [4:0] a);
        case (a)
            5'd0:  return m_ctrl;
            5'd1:  return 16'h7809 | (16'(an_done) << 5) | (16'(m_rf) << 4) |
                          (16'(m_link) << 2) | (16'(m_jab) << 1);
            5'd2:  return 16'h0203;
            5'd3:  return 16'h5C41;
            5'd4:  return m_adv;
            5'd5:  return lp_ability;
            5'd6:  return (16'(m_page) << 1) | 16'(lp_ability != 0);
            5'd16: return m_cfg;
            5'd17: return {10'b0, m_isr};
            5'd18: return m_ier;
            5'd19: return 16'(m_cnt);
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            model_defaults();
            m_rdata = 16'h0000;
            m_last  = 5'd0;
        end else begin
            bit rd;
            int nxt;
            bit hit;
            rd = acc_en && !acc_wr;
            if (rd) begin
                m_rdata = model_read(acc_addr);
                m_last  = acc_addr;
            end
            if (acc_en && acc_wr && acc_addr == 5'd0 && acc_wdata[15]) begin
                model_defaults();
            end else begin
                if (acc_en && acc_wr) begin
                    if (acc_addr == 5'd0)  m_ctrl = (m_ctrl & ~16'h7D00) | (acc_wdata & 16'h7D00);
                    if (acc_addr == 5'd4)  m_adv  = (m_adv  & ~16'h25E0) | (acc_wdata & 16'h25E0);
                    if (acc_addr == 5'd16) m_cfg  = (m_cfg  & ~16'h000F) | (acc_wdata & 16'h000F);
                    if (acc_addr == 5'd18) m_ier  = (m_ier  & ~16'h003F) | (acc_wdata & 16'h003F);
                end
                m_link = (rd && acc_addr == 5'd1) ? link_ok : (m_link && link_ok);
                m_jab  = ((rd && acc_addr == 5'd1) ? 1'b0 : m_jab) | jabber;
                m_rf   = ((rd && acc_addr == 5'd1) ? 1'b0 : m_rf) | remote_fault;
                m_page = ((rd && acc_addr == 5'd6) ? 1'b0 : m_page) | page_rx;
                if (rd && acc_addr == 5'd19) nxt = rx_err ? 1 : 0;
                else if (rx_err && m_cnt < 65535) nxt = m_cnt + 1;
                else nxt = m_cnt;
                hit   = rx_err && (nxt == 64);
                m_cnt = nxt;
                if (rd && acc_addr == 5'd17) m_isr = '0;
                m_isr = m_isr | {an_done, remote_fault, jabber, !link_ok, page_rx, hit};
            end
        end
    end

    function automatic string tag_of(logic [4:0] a);
        case (a)
            5'd1:  return "R7/R8";
            5'd6:  return "R8";
            5'd17: return "R9";
            5'd19: return "R10";
            5'd0, 5'd4, 5'd16, 5'd18: return "R3";
            default: return "R1";
        endcase
    endfunction

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            n_chk += 2;
            if (acc_rdata !== m_rdata) begin
                n_err++;
                $display("FAIL %s/R2 model rdata addr %0d: got %h exp %h", tag_of(m_last), m_last, acc_rdata, m_rdata);
            end
            if (irq !== |(m_isr & m_ier[5:0])) begin
                n_err++;
                $display("FAIL R11 model irq: got %b exp %b", irq, |(m_isr & m_ier[5:0]));
            end
        end
    end

    // ---------------- directed stimulus ----------------
    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr_reg(logic [4:0] a, logic [15:0] d);
        acc_en = 1; acc_wr = 1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_en = 0; acc_wr = 0;
    endtask

    task automatic rd_reg(logic [4:0] a, string req, logic [15:0] exp);
        acc_en = 1; acc_wr = 0; acc_addr = a;
        @(negedge clk);
        acc_en = 0;
        chk(req, acc_rdata, exp);
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(negedge clk);
                n_err++; n_chk++;
                $display("FAIL watchdog expired");
                $display("Result: errors=%0d of %0d checks", n_err, n_chk);
                $finish;
            end
        join_none

        @(negedge clk);
        do_reset();
        chk("R2 reset rdata", acc_rdata, 16'h0000);
        rd_reg(5'd0,  "R5 control default",    16'h3100);
        rd_reg(5'd16, "R5 isolate strap",      16'h0001);
        rd_reg(5'd4,  "R6 adv strap",          16'h0181);
        rd_reg(5'd2,  "R1 id high",            16'h0203);
        repeat (3) @(negedge clk);
        chk("R2 rdata held", acc_rdata, 16'h0203);
        rd_reg(5'd7,  "R1 unimplemented 7",    16'h0000);
        rd_reg(5'd31, "R1 unimplemented 31",   16'h0000);
        rd_reg(5'd5,  "R8 partner ability",    16'h41E1);

        rd_reg(5'd1, "R7 link low after reset", 16'h7809);
        rd_reg(5'd1, "R7 link reloaded",        16'h780D);
        wr_reg(5'd1, 16'hFFFF);
        rd_reg(5'd1, "R3 status write ignored", 16'h780D);
        wr_reg(5'd0, 16'h7FFF);
        rd_reg(5'd0, "R3 control mask",         16'h7D00);
        wr_reg(5'd4, 16'hFFFF);
        rd_reg(5'd4, "R3 adv mask",             16'h25E1);

        jabber = 1; @(negedge clk); jabber = 0;
        rd_reg(5'd1, "R8 jabber latched", 16'h780F);
        rd_reg(5'd1, "R8 jabber cleared", 16'h780D);
        wr_reg(5'd18, 16'h0008);
        chk("R11 irq raised", {15'b0, irq}, 16'h0001);
        rd_reg(5'd17, "R9 isr jabber", 16'h0008);
        chk("R11 irq dropped", {15'b0, irq}, 16'h0000);
        rd_reg(5'd17, "R9 isr empty", 16'h0000);

        link_ok = 0; @(negedge clk); link_ok = 1;
        rd_reg(5'd1, "R7 link drop held", 16'h7809);
        rd_reg(5'd1, "R7 link back",      16'h780D);
        rd_reg(5'd17, "R9 isr link",      16'h0004);

        page_rx = 1;
        rd_reg(5'd17, "R9 read in event cycle", 16'h0000);
        page_rx = 0;
        rd_reg(5'd17, "R9 event survived",      16'h0002);
        rd_reg(5'd6,  "R8 page latched",        16'h0003);
        rd_reg(5'd6,  "R8 page cleared",        16'h0001);

        wr_reg(5'd18, 16'h0001);
        rx_err = 1; repeat (63) @(negedge clk); rx_err = 0;
        chk("R10 no irq at 63", {15'b0, irq}, 16'h0000);
        rd_reg(5'd17, "R10 isr at 63", 16'h0000);
        rx_err = 1; @(negedge clk); rx_err = 0;
        chk("R10 irq at 64", {15'b0, irq}, 16'h0001);
        rd_reg(5'd19, "R10 count",         16'd64);
        rd_reg(5'd19, "R10 count cleared", 16'd0);
        rd_reg(5'd17, "R10 threshold bit", 16'h0001);

        wr_reg(5'd18, 16'h003F);
        jabber = 1; @(negedge clk); jabber = 0;
        wr_reg(5'd0, 16'h8000);
        rd_reg(5'd0,  "R4 control back",   16'h3100);
        rd_reg(5'd18, "R4 enable cleared", 16'h0000);
        rd_reg(5'd4,  "R4 adv back",       16'h0181);
        rd_reg(5'd17, "R4 isr cleared",    16'h0000);

        strap_an_en = 0; strap_phy_addr = 5'd3; strap_adv_sel = 2'd2;
        do_reset();
        rd_reg(5'd0,  "R5 control no-an",  16'h2100);
        rd_reg(5'd16, "R5 no isolate",     16'h0000);
        rd_reg(5'd4,  "R6 adv fixed",      16'h01E1);

        strap_an_en = 1; strap_adv_sel = 2'd3;
        do_reset();
        rd_reg(5'd4,  "R6 adv map 3",      16'h0061);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule